// File: doc/BRIEF.md
# Multiplexed IQ Receive Interleaver

This block sits between a pair of receive converters and a baseband device. It takes one I word and one Q word per sampling instant and time-multiplexes them onto a single output bus of the same width. A frame-select flag says which of the two words is on the bus at the moment. The bus clock comes from the baseband at twice the converter sample rate, and the block works on its rising edge. The block divides this clock by two to make the converter sampling strobe.

Three configuration inputs shape the stream:
- `cfg_q_first` picks the word order inside a frame.
- `cfg_sel_invert` picks the flag polarity.
- `cfg_cap_rise` picks which edge of the divided strobe loads new converter words.

Order and polarity are taken at the start of each frame, so a frame never mixes two settings. Both words shown in one frame always come from the same capture.

A small state machine sequences the frames. Its states are:
- ST_IDLE: held in reset.
- ST_PRIME: one clock after reset release, while the first pair is captured.
- ST_LEAD: the first word of a frame is on the bus.
- ST_TRAIL: the second word of a frame is on the bus.

Its transitions are:
- ST_IDLE to ST_PRIME on the first edge after reset release.
- ST_PRIME to ST_LEAD.
- ST_LEAD to ST_TRAIL.
- ST_TRAIL to ST_LEAD, repeating without end.

Top module: `iq_rx_interleaver`

## Requirements
- R1: While reset is asserted, and after the first rising edge following its release, `bus_data` is 0, `bus_sel` is 0 and `smp_strobe` is 0.
- R2: From the second edge after release, `smp_strobe` is 1 after every edge that starts a frame and 0 after every edge that ends one. It therefore toggles every clock, with a period of two bus clocks.
- R3: The first word of the first full frame appears after the second rising edge following reset release. Edges are counted from 1 at the first edge after release.
- R4: The two words of one frame are the unaltered I and Q words (two's complement, bit DATA_W-1 the MSB) from one single capture.
- R5: With `cfg_q_first`=0 a frame carries I then Q; with `cfg_q_first`=1 it carries Q then I.
- R6: `bus_sel` is 1 while an I word is on the bus and 0 while a Q word is on the bus when `cfg_sel_invert`=0. Both levels are swapped when `cfg_sel_invert`=1.
- R7: The first edge after release always captures the converter words. After that, `cfg_cap_rise`=0 captures on each edge where `smp_strobe` falls (odd edges 3, 5, ...). `cfg_cap_rise`=1 captures on each edge where it rises (even edges 2, 4, ...). A frame starting at edge 2k therefore shows the words captured at edge 2k-1 (falling-edge capture), or at edge 2k-2 for k>=2 and edge 1 for k=1 (rising-edge capture).
- R8: `cfg_q_first` and `cfg_sel_invert` are sampled at the edge that starts a frame. A change made during a frame's lead word does not affect that frame's trail word and takes effect with the next frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock, twice the converter sample rate, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| cfg_q_first | input | 1 | 0: I word leads each frame, 1: Q word leads |
| cfg_sel_invert | input | 1 | 0: flag high on I word, 1: flag high on Q word |
| cfg_cap_rise | input | 1 | 0: capture on falling strobe edge, 1: on rising strobe edge |
| adc_i | input | DATA_W | I converter word, two's complement |
| adc_q | input | DATA_W | Q converter word, two's complement |
| smp_strobe | output | 1 | Converter sampling strobe, bus clock divided by two |
| bus_data | output | DATA_W | Multiplexed output word |
| bus_sel | output | 1 | Frame-select flag marking the word on the bus |

## Verification
The bench builds the block with its default width of 12 bits. It sweeps all eight combinations of order, polarity and capture edge. Each combination gets a fresh reset and seven frames.

The converter inputs change on every clock to values computed from the edge number. A word captured one edge too early or too late, a pair split across two captures, or a swapped order or flag therefore shows up as a data mismatch. Extra runs flip order and polarity in the middle of a frame, in both capture modes, to reach the frame-boundary sampling rule.

// File: rtl/iqil_pkg.sv
package iqil_pkg;

    // Frame sequencer states
    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_PRIME = 2'd1,
        ST_LEAD  = 2'd2,
        ST_TRAIL = 2'd3
    } seq_state_t;

    // Configuration bundle carried between submodules
    typedef struct packed {
        logic q_first;
        logic sel_invert;
        logic cap_on_rise;
    } iqil_cfg_t;

endpackage

// File: rtl/iqil_sequencer.sv
module iqil_sequencer
    import iqil_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic cap_on_rise,
    output logic lead_go,
    output logic trail_go,
    output logic cap_en,
    output logic strobe
);

    seq_state_t state_q;
    seq_state_t state_d;

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // Next-state selection
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:  state_d = ST_PRIME;
            ST_PRIME: state_d = ST_LEAD;
            ST_LEAD:  state_d = ST_TRAIL;
            ST_TRAIL: state_d = ST_LEAD;
        endcase
    end

    // Per-state strobes for the datapath
    always_comb begin
        lead_go  = 1'b0;
        trail_go = 1'b0;
        cap_en   = 1'b0;
        unique case (state_q)
            ST_IDLE: begin
                cap_en = 1'b1;
            end
            ST_PRIME: begin
                lead_go = 1'b1;
                cap_en  = cap_on_rise;
            end
            ST_LEAD: begin
                trail_go = 1'b1;
                cap_en   = !cap_on_rise;
            end
            ST_TRAIL: begin
                lead_go = 1'b1;
                cap_en  = cap_on_rise;
            end
        endcase
    end

    // Divided sampling strobe: high during the lead half of a frame
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            strobe <= 1'b0;
        end else begin
            strobe <= lead_go;
        end
    end

    // R3: the first frame begins two edges after release
    p_idle_to_prime_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_IDLE) |=> (state_q == ST_PRIME));
    p_prime_to_lead_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_PRIME) |=> (state_q == ST_LEAD));

    // R2: strobe rises entering the lead half and falls entering the trail half
    p_strobe_high_lead_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_TRAIL) |=> strobe);
    p_strobe_low_trail_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_LEAD) |=> !strobe);

endmodule

// File: rtl/iqil_capture.sv
module iqil_capture #(
    parameter int DATA_W = 12
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cap_en,
    input  logic [DATA_W-1:0] adc_i,
    input  logic [DATA_W-1:0] adc_q,
    output logic [DATA_W-1:0] hold_i,
    output logic [DATA_W-1:0] hold_q
);

    // Both converter words are loaded on the same edge
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            hold_i <= '0;
            hold_q <= '0;
        end else if (cap_en) begin
            hold_i <= adc_i;
            hold_q <= adc_q;
        end
    end

    // R7: the captured pair changes only on a capture edge
    p_hold_stable_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !cap_en |=> ($stable(hold_i) && $stable(hold_q)));

endmodule

// File: rtl/iqil_serializer.sv
module iqil_serializer
    import iqil_pkg::*;
#(
    parameter int DATA_W = 12
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              lead_go,
    input  logic              trail_go,
    input  iqil_cfg_t         cfg,
    input  logic [DATA_W-1:0] hold_i,
    input  logic [DATA_W-1:0] hold_q,
    output logic [DATA_W-1:0] bus_data,
    output logic              bus_sel
);

    logic              frm_q_first;
    logic              frm_invert;
    logic [DATA_W-1:0] trail_word;

    // Lead half: choose the order, park the second word, latch frame settings.
    // Trail half: emit the parked word with the flag of the other component.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            frm_q_first <= 1'b0;
            frm_invert  <= 1'b0;
            trail_word  <= '0;
            bus_data    <= '0;
            bus_sel     <= 1'b0;
        end else if (lead_go) begin
            frm_q_first <= cfg.q_first;
            frm_invert  <= cfg.sel_invert;
            bus_data    <= cfg.q_first ? hold_q : hold_i;
            trail_word  <= cfg.q_first ? hold_i : hold_q;
            bus_sel     <= (!cfg.q_first) ^ cfg.sel_invert;
        end else if (trail_go) begin
            bus_data    <= trail_word;
            bus_sel     <= frm_q_first ^ frm_invert;
        end
    end

    // R6: the flag level during the trail word is opposite to the lead word's
    p_trail_flag_flip_r6: assert property (@(posedge clk) disable iff (!rst_n)
        trail_go |=> (bus_sel != $past(bus_sel)));

endmodule

// File: rtl/iq_rx_interleaver.sv
module iq_rx_interleaver
    import iqil_pkg::*;
#(
    parameter int DATA_W = 12
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_q_first,
    input  logic              cfg_sel_invert,
    input  logic              cfg_cap_rise,
    input  logic [DATA_W-1:0] adc_i,
    input  logic [DATA_W-1:0] adc_q,
    output logic              smp_strobe,
    output logic [DATA_W-1:0] bus_data,
    output logic              bus_sel
);

    iqil_cfg_t         cfg;
    logic              lead_go;
    logic              trail_go;
    logic              cap_en;
    logic [DATA_W-1:0] hold_i;
    logic [DATA_W-1:0] hold_q;

    assign cfg = '{q_first: cfg_q_first, sel_invert: cfg_sel_invert,
                   cap_on_rise: cfg_cap_rise};

    iqil_sequencer u_seq (
        .clk         (clk),
        .rst_n       (rst_n),
        .cap_on_rise (cfg.cap_on_rise),
        .lead_go     (lead_go),
        .trail_go    (trail_go),
        .cap_en      (cap_en),
        .strobe      (smp_strobe)
    );

    iqil_capture #(.DATA_W(DATA_W)) u_cap (
        .clk    (clk),
        .rst_n  (rst_n),
        .cap_en (cap_en),
        .adc_i  (adc_i),
        .adc_q  (adc_q),
        .hold_i (hold_i),
        .hold_q (hold_q)
    );

    iqil_serializer #(.DATA_W(DATA_W)) u_ser (
        .clk      (clk),
        .rst_n    (rst_n),
        .lead_go  (lead_go),
        .trail_go (trail_go),
        .cfg      (cfg),
        .hold_i   (hold_i),
        .hold_q   (hold_q),
        .bus_data (bus_data),
        .bus_sel  (bus_sel)
    );

    // R2: once running, the strobe toggles on every edge
    p_strobe_toggles_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (lead_go || trail_go) |=> (smp_strobe != $past(smp_strobe)));

endmodule

// File: tb/iq_rx_interleaver_bench.sv
module iq_rx_interleaver_bench;

    localparam int CLK_PERIOD = 10;
    localparam int DW         = 12;
    localparam int MASK       = (1 << DW) - 1;
    localparam int EDGES      = 14;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          cfg_q_first = 1'b0;
    logic          cfg_sel_invert = 1'b0;
    logic          cfg_cap_rise = 1'b0;
    logic [DW-1:0] adc_i = '0;
    logic [DW-1:0] adc_q = '0;
    logic          smp_strobe;
    logic [DW-1:0] bus_data;
    logic          bus_sel;

    int total = 0;
    int bad = 0;
    bit done = 1'b0;
    int in_i [0:EDGES+1];
    int in_q [0:EDGES+1];

    always #(CLK_PERIOD/2) clk = ~clk;

    iq_rx_interleaver #(.DATA_W(DW)) u_iq_rx_interleaver (
        .clk            (clk),
        .rst_n          (rst_n),
        .cfg_q_first    (cfg_q_first),
        .cfg_sel_invert (cfg_sel_invert),
        .cfg_cap_rise   (cfg_cap_rise),
        .adc_i          (adc_i),
        .adc_q          (adc_q),
        .smp_strobe     (smp_strobe),
        .bus_data       (bus_data),
        .bus_sel        (bus_sel)
    );

    task automatic chk(input string tag, input int act, input int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // One run: reset, then EDGES clock edges; flip_at > 0 flips order and
    // polarity after the check that follows that edge.
    task automatic run(input int cfgv, input int flip_at);
        bit fq;
        bit finv;
        fq   = 1'b0;
        finv = 1'b0;
        @(negedge clk);
        rst_n          = 1'b0;
        cfg_q_first    = cfgv[0];
        cfg_sel_invert = cfgv[1];
        cfg_cap_rise   = cfgv[2];
        @(negedge clk);
        // R1: reset state
        chk("R1 reset bus_data", int'(bus_data), 0);
        chk("R1 reset bus_sel", int'(bus_sel), 0);
        chk("R1 reset strobe", int'(smp_strobe), 0);
        for (int e = 1; e <= EDGES; e++) begin
            in_i[e] = (e * 173 + cfgv * 29 + flip_at * 7 + 11) & MASK;
            in_q[e] = ((e * 301 + cfgv * 5 + 7) ^ 'hA5A) & MASK;
        end
        adc_i = DW'(in_i[1]);
        adc_q = DW'(in_q[1]);
        rst_n = 1'b1;
        for (int n = 1; n <= EDGES; n++) begin
            @(posedge clk);
            @(negedge clk);
            if (n == 1) begin
                // R1 and R3: still quiet after the first edge
                chk("R1 first edge bus_data", int'(bus_data), 0);
                chk("R1 first edge bus_sel", int'(bus_sel), 0);
                chk("R3 first edge strobe", int'(smp_strobe), 0);
            end else begin
                int  k;
                int  c;
                bit  lead_i;
                bit  is_i;
                int  word;
                if ((n % 2) == 0) begin
                    fq   = cfg_q_first;
                    finv = cfg_sel_invert;
                end
                k = n / 2;
                if (cfg_cap_rise) c = (k == 1) ? 1 : 2 * k - 2;
                else              c = 2 * k - 1;
                lead_i = !fq;
                is_i   = ((n % 2) == 0) ? lead_i : !lead_i;
                word   = is_i ? in_i[c] : in_q[c];
                chk("R2 strobe phase", int'(smp_strobe), ((n % 2) == 0) ? 1 : 0);
                if (flip_at > 0 && n > flip_at) begin
                    chk("R8 data after mid-frame change", int'(bus_data), word);
                    chk("R8 flag after mid-frame change", int'(bus_sel), int'(is_i ^ finv));
                end else if (n == 2) begin
                    chk("R3 first lead word", int'(bus_data), word);
                    chk("R6 first lead flag", int'(bus_sel), int'(is_i ^ finv));
                end else begin
                    chk(cfg_cap_rise ? "R7 rise capture R4 R5 data" : "R7 fall capture R4 R5 data",
                        int'(bus_data), word);
                    chk("R6 flag level", int'(bus_sel), int'(is_i ^ finv));
                end
            end
            if (flip_at > 0 && n == flip_at) begin
                cfg_q_first    = !cfg_q_first;
                cfg_sel_invert = !cfg_sel_invert;
            end
            if (n < EDGES) begin
                adc_i = DW'(in_i[n+1]);
                adc_q = DW'(in_q[n+1]);
            end
        end
    endtask

    initial begin
        for (int cfgv = 0; cfgv < 8; cfgv++) begin
            run(cfgv, 0);
        end
        // R8: flip settings during a lead word, in both capture modes
        run(0, 6);
        run(5, 8);
        run(6, 4);
        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

endmodule